// File: doc/BRIEF.md
# ADC Serial Readout Shift Interface

This block is the digital output side of a dual-channel successive-approximation converter. A host frames each transfer with an active-low select and supplies its own serial clock. The block presents a 16-bit frame on one data line with a separate output enable, so that the pin can be three-stated. It also reports whether the sampling stage is holding or tracking, and it flags frames that end too early.

The conversion result and the channel identifier arrive as parallel inputs. The frame layout and the mode are captured when select falls. Select and the serial clock are sampled by the system clock `clk_i`, which must run at least twice as fast as the serial clock. Select going low drives the enable, and the first frame bit, onto the pin at once. Each falling serial-clock edge then advances the frame by one bit. Two modes are supported: a full 12-bit result, and a short 10-bit result followed by zero padding.

Top module: `adc_so_top`

## Requirements
- R1: When `cs_ni` falls, `oe_o` goes high in the same cycle, combinationally. `hold_o` is high from the next `clk_i` edge.
- R2: Frame bits are numbered b0..b15. b0, b1 and b3 are 0 and b2 is the latched `chan_i`. b0 is on `dout_o` as soon as `cs_ni` is low.
- R3: The k-th sampled falling edge of `sclk_i` puts b_k on `dout_o` one `clk_i` cycle later, for k=1..15. In full mode (`mode_short_i`=0), b4..b15 carry `result_i[11]` down to `result_i[0]`.
- R4: `hold_o` stays high until 13 falling `sclk_i` edges have been seen. It drops on the first rising `sclk_i` edge after that.
- R5: After the 16th falling edge, `oe_o` goes low. Any further `sclk_i` activity in the same frame leaves `oe_o` low and `dout_o` at 0.
- R6: In short mode (`mode_short_i`=1), b4..b13 carry `result_i[9]` down to `result_i[0]`, and b14 and b15 are 0.
- R7: When `cs_ni` rises, `oe_o` goes low combinationally. `hold_o` is low from the next `clk_i` edge.
- R8: `abort_o` pulses high for one cycle after `cs_ni` rises if fewer falling edges were seen than the mode requires: 16 in full mode, 14 in short mode. Otherwise it stays low.
- R9: `result_i`, `chan_i` and `mode_short_i` are captured only when `cs_ni` falls. Changing them during a frame does not change that frame.
- R10: While `rst_ni` is low, `oe_o`, `dout_o`, `hold_o` and `abort_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples select and the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Host serial clock |
| mode_short_i | input | 1 | 1 selects the 10-bit result with trailing zeros |
| chan_i | input | 1 | Channel identifier placed in b2 |
| result_i | input | 12 | Conversion result; the short mode uses bits 9..0 |
| dout_o | output | 1 | Serial data, valid while oe_o is high |
| oe_o | output | 1 | Output enable for the three-state data pin |
| hold_o | output | 1 | 1 while holding the sample, 0 while tracking |
| abort_o | output | 1 | One-cycle pulse on an early frame end |

## Verification
The bench checks that the first zero and the enable appear before any clock edge after select falls. A design that registered them would show a high-impedance pin during the first half bit. It checks the hold release between the 13th falling edge and the 14th rising edge: a counter that is off by one would release too early or too late. It compares the abort flag at 13 and 14 edges in short mode and at 15 and 16 in full mode, where a design that ignored the mode would flag the wrong case. It also toggles the inputs in mid-frame and clocks the serial clock after the frame end. A design without input capture would then shift corrupted bits, and one without an end-of-frame stop would drive the pin again.

// File: rtl/adc_so_pkg.sv
package adc_so_pkg;
  localparam int unsigned DEF_RES_W       = 12;
  localparam int unsigned DEF_SHORT_W     = 10;
  localparam int unsigned DEF_FRAME_LEN   = 16;
  localparam int unsigned DEF_TRACK_AFTER = 13;
  localparam int unsigned DEF_SHORT_CONV  = 14;
  localparam int unsigned CHAN_POS        = 2;

  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_SHORT = 1'b1
  } res_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/adc_so_edge.sv
module adc_so_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sig_i,
  output adc_so_pkg::edge_t    edge_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= RST_VAL;
    else         sig_q <= sig_i;
  end

  // combinational against the live input so select acts within the cycle
  assign edge_o.rise = ~sig_q & sig_i;
  assign edge_o.fall = sig_q & ~sig_i;
endmodule

// File: rtl/adc_so_ctrl.sv
module adc_so_ctrl #(
  parameter int unsigned FRAME_LEN   = adc_so_pkg::DEF_FRAME_LEN,
  parameter int unsigned TRACK_AFTER = adc_so_pkg::DEF_TRACK_AFTER,
  parameter int unsigned SHORT_CONV  = adc_so_pkg::DEF_SHORT_CONV,
  localparam int unsigned CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  adc_so_pkg::edge_t     cs_edge_i,
  input  adc_so_pkg::edge_t     sclk_edge_i,
  input  adc_so_pkg::res_mode_e mode_i,
  output logic                  active_o,
  output logic                  shift_o,
  output logic                  hold_o,
  output logic                  abort_o
);
  import adc_so_pkg::*;

  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TRACK_CNT = CNT_W'(TRACK_AFTER);
  localparam logic [CNT_W-1:0] FULL_NEED = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] SHRT_NEED = CNT_W'(SHORT_CONV);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q, hold_q, in_frame_q, abort_q;
  res_mode_e        mode_q;
  logic [CNT_W-1:0] need;
  logic             cs_fall, cs_rise;

  assign cs_fall = cs_edge_i.fall;
  assign cs_rise = cs_edge_i.rise;
  assign need    = (mode_q == MODE_SHORT) ? SHRT_NEED : FULL_NEED;
  assign shift_o = sclk_edge_i.fall & active_q & ~cs_fall & ~cs_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      active_q   <= 1'b0;
      hold_q     <= 1'b0;
      in_frame_q <= 1'b0;
      abort_q    <= 1'b0;
      mode_q     <= MODE_FULL;
    end else begin
      abort_q <= 1'b0;
      if (cs_fall) begin
        cnt_q      <= '0;
        active_q   <= 1'b1;
        hold_q     <= 1'b1;
        in_frame_q <= 1'b1;
        mode_q     <= mode_i;
      end else if (cs_rise) begin
        active_q   <= 1'b0;
        hold_q     <= 1'b0;
        in_frame_q <= 1'b0;
        abort_q    <= in_frame_q & (cnt_q < need);
      end else begin
        if (shift_o) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_CNT) active_q <= 1'b0;
        end
        if (sclk_edge_i.rise && hold_q && cnt_q >= TRACK_CNT) hold_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign hold_o   = hold_q;
  assign abort_o  = abort_q;

  // R1
  hold_on_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> hold_q);
  // R4
  track_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> ($past(cnt_q) >= TRACK_CNT) || $past(cs_rise));
  // R5
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && cnt_q == LAST_CNT) |=> !active_q);
  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_NEED);
  // R8
  abort_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> $past(cs_rise) && $past(in_frame_q));
endmodule

// File: rtl/adc_so_shifter.sv
module adc_so_shifter #(
  parameter int unsigned RES_W     = adc_so_pkg::DEF_RES_W,
  parameter int unsigned SHORT_W   = adc_so_pkg::DEF_SHORT_W,
  parameter int unsigned FRAME_LEN = adc_so_pkg::DEF_FRAME_LEN
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  adc_so_pkg::res_mode_e mode_i,
  input  logic                  chan_i,
  input  logic [RES_W-1:0]      result_i,
  output logic                  msb_o
);
  import adc_so_pkg::*;

  localparam int unsigned PAD = RES_W - SHORT_W;

  logic [FRAME_LEN-1:0] frame, sh_q;

  always_comb begin
    frame = '0;
    frame[FRAME_LEN-1-CHAN_POS] = chan_i;
    for (int i = 0; i < RES_W; i++) begin
      if (mode_i == MODE_FULL) frame[i] = result_i[i];
      else if (i < SHORT_W)    frame[i + PAD] = result_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= frame;
    else if (shift_i) sh_q <= {sh_q[FRAME_LEN-2:0], 1'b0};
  end

  assign msb_o = sh_q[FRAME_LEN-1];

  // R3
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sh_q));
endmodule

// File: rtl/adc_so_top.sv
module adc_so_top #(
  parameter int unsigned RES_W       = adc_so_pkg::DEF_RES_W,
  parameter int unsigned SHORT_W     = adc_so_pkg::DEF_SHORT_W,
  parameter int unsigned FRAME_LEN   = adc_so_pkg::DEF_FRAME_LEN,
  parameter int unsigned TRACK_AFTER = adc_so_pkg::DEF_TRACK_AFTER,
  parameter int unsigned SHORT_CONV  = adc_so_pkg::DEF_SHORT_CONV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             mode_short_i,
  input  logic             chan_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o,
  output logic             oe_o,
  output logic             hold_o,
  output logic             abort_o
);
  import adc_so_pkg::*;

  edge_t     cs_edge, sclk_edge;
  res_mode_e mode;
  logic      active, shift, msb;

  assign mode = mode_short_i ? MODE_SHORT : MODE_FULL;

  adc_so_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(cs_ni), .edge_o(cs_edge));

  adc_so_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sclk_i), .edge_o(sclk_edge));

  adc_so_ctrl #(
    .FRAME_LEN(FRAME_LEN), .TRACK_AFTER(TRACK_AFTER), .SHORT_CONV(SHORT_CONV)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_edge_i(cs_edge), .sclk_edge_i(sclk_edge),
    .mode_i(mode), .active_o(active), .shift_o(shift), .hold_o(hold_o),
    .abort_o(abort_o));

  adc_so_shifter #(
    .RES_W(RES_W), .SHORT_W(SHORT_W), .FRAME_LEN(FRAME_LEN)
  ) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cs_edge.fall), .shift_i(shift),
    .mode_i(mode), .chan_i(chan_i), .result_i(result_i), .msb_o(msb));

  // pending select fall drives the pin before the first clock edge
  assign oe_o   = ~cs_ni & (cs_edge.fall | active) & rst_ni;
  assign dout_o = oe_o & active & msb;

  // R7
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !oe_o);
endmodule

// File: tb/adc_so_top_tb.sv
module adc_so_top_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sclk = 1'b0;
  logic        mode_short = 1'b0;
  logic        chan = 1'b0;
  logic [11:0] result = '0;
  logic        dout, oe, hold, abort;
  wire         pin;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  adc_so_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk),
    .mode_short_i(mode_short), .chan_i(chan), .result_i(result),
    .dout_o(dout), .oe_o(oe), .hold_o(hold), .abort_o(abort));

  assign pin = oe ? dout : 1'bz;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input int k, input logic shrt, input logic ch,
                                   input logic [11:0] r);
    if (k < 2 || k == 3) return 1'b0;
    if (k == 2) return ch;
    if (shrt) return (k <= 13) ? r[13-k] : 1'b0;
    return r[15-k];
  endfunction

  task automatic sclk_up();
    @(negedge clk) sclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic sclk_down();
    @(negedge clk) sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_frame(input logic shrt, input logic ch, input logic [11:0] r);
    @(negedge clk);
    mode_short = shrt; chan = ch; result = r;
    cs_ni = 1'b0;
    #1;
    chk("R1 oe on select", oe, 1);
    chk("R2 first zero", pin, 0);
    @(negedge clk);
    chk("R1 hold", hold, 1);
    chk("R2 b0", dout, 0);
  endtask

  task automatic run_frame(input logic shrt, input logic ch, input logic [11:0] r,
                           input bit scramble);
    start_frame(shrt, ch, r);
    if (scramble) begin
      mode_short = ~shrt; chan = ~ch; result = ~r;
    end
    for (int k = 1; k <= 16; k++) begin
      sclk_up();
      if (k == 13) chk("R4 hold before 13 falls", hold, 1);
      if (k == 14) chk("R4 track after 13 falls", hold, 0);
      sclk_down();
      if (k < 16) begin
        chk(scramble ? "R9 latched bit" : (k < 4 ? "R2 header" :
            (shrt && k >= 14) ? "R6 trailing zero" : "R3 data"),
            {31'd0, pin}, {31'd0, exp_bit(k, shrt, ch, r)});
      end else begin
        chk("R5 oe off at 16", oe, 0);
      end
    end
    sclk_up();
    sclk_down();
    chk("R5 extra sclk oe", oe, 0);
    chk("R5 extra sclk dout", dout, 0);
    @(negedge clk) cs_ni = 1'b1;
    @(negedge clk);
    chk("R8 no abort on full frame", abort, 0);
  endtask

  task automatic abort_frame(input logic shrt, input int nf, input logic exp_ab);
    start_frame(shrt, 1'b1, 12'hFFF);
    for (int k = 1; k <= nf; k++) begin
      sclk_up();
      sclk_down();
    end
    @(negedge clk) cs_ni = 1'b1;
    #1;
    chk("R7 oe off on select rise", oe, 0);
    @(negedge clk);
    chk("R8 abort pulse", abort, {31'd0, exp_ab});
    chk("R7 hold released", hold, 0);
    @(negedge clk);
    chk("R8 abort one cycle", abort, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 oe", oe, 0);
    chk("R10 dout", dout, 0);
    chk("R10 hold", hold, 0);
    chk("R10 abort", abort, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(1'b0, 1'b1, 12'hA5C, 1'b0);
    run_frame(1'b0, 1'b0, 12'h3F1, 1'b1);
    run_frame(1'b1, 1'b1, 12'h2B7, 1'b0);
    run_frame(1'b1, 1'b0, 12'h155, 1'b1);
    abort_frame(1'b0, 15, 1'b1);
    abort_frame(1'b1, 14, 1'b0);
    abort_frame(1'b1, 13, 1'b1);
    abort_frame(1'b0, 5, 1'b1);
    run_frame(1'b0, 1'b1, 12'h801, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule